// File: doc/BRIEF.md
# Bidirectional Scanning Row Driver Logic

This block is the digital core of a 40-channel display row driver. A 40-stage shift register carries a scan token. The token moves one stage on every rising clock edge. A direction input chooses which of the two chain ends takes serial data and which end drives the cascade output. Several drivers can therefore be chained in either scan order.

A seed input can be raised in any clock cycle. It clears the chain and places one logic high at the input end. Each channel turns its register bit into one of three abstract drive states: high-impedance, drive-low or drive-high. A polarity input picks the drive state, and a global disable input forces every channel to high-impedance.

Each bidirectional end pin is modelled as three signals: an input, an output and an output enable. The pin on the input side has its enable low, so a cascaded neighbour can drive that pin. The scan moves one stage on every clock edge and has no stall, so the serial path has no valid/ready handshake.

Top module: `row_scan_driver`

## Requirements
- R1: While `rst_n` is low, all stages are zero and every channel reads 00. This reset is asynchronous and takes effect without waiting for a clock edge.
- R2: When `seed` is sampled high at a rising edge with `dir` high, the chain holds a 1 in stage 0 and 0 in all other stages.
- R3: When `seed` is sampled high at a rising edge with `dir` low, the chain holds a 1 in stage 39 and 0 in all other stages.
- R4: With `seed` low and `dir` high, each rising edge moves stage i into stage i+1, and `end_a_in` is loaded into stage 0.
- R5: With `seed` low and `dir` low, each rising edge moves stage i+1 into stage i, and `end_b_in` is loaded into stage 39.
- R6: With `dir` high, `end_b_en`=1, `end_b_out` equals stage 39 and `end_a_en`=0. With `dir` low, `end_a_en`=1, `end_a_out` equals stage 0 and `end_b_en`=0.
- R7: Channel i uses bits `ch_state[2i+1:2i]`. When its stage is 1 and `oe` is low, it reads 10 (drive-high) if `pol` is 1, and 01 (drive-low) if `pol` is 0.
- R8: A channel whose stage is 0 reads 00 (high-impedance).
- R9: While `oe` is high, every channel reads 00, whatever the stages or `pol`.
- R10: The code 11 never appears on any channel.
- R11: A seed overrides any tokens already in the chain and the serial input in the same cycle. Exactly one stage is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the chain advances on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed | input | 1 | Synchronous chain clear and token load |
| dir | input | 1 | Scan direction: 1 means A is the input end, 0 means B is the input end |
| pol | input | 1 | Drive polarity for active channels: 1 high, 0 low |
| oe | input | 1 | Global disable, active high |
| end_a_in | input | 1 | Value received at end pin A |
| end_a_out | output | 1 | Value driven onto end pin A |
| end_a_en | output | 1 | Output enable for end pin A |
| end_b_in | input | 1 | Value received at end pin B |
| end_b_out | output | 1 | Value driven onto end pin B |
| end_b_en | output | 1 | Output enable for end pin B |
| ch_state | output | 80 | Two bits per channel: 00 high-Z, 01 low, 10 high |

## Verification
All chain state is visible at the ports. With `oe` low and `pol` high, bit 2i+1 of `ch_state` equals stage i. A wrong stage therefore shows in the sample taken just after the edge that wrote it. A bad shift or seed shows as a token at the wrong index, a missing token or a second token, one cycle after the faulty edge. A wrong pin-direction choice shows at once on the end-pin enables. A fault that corrupts the cascade only shows when the token reaches the output end, up to 39 edges later, so the bench runs the token to both ends of the chain.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;
  typedef enum logic [1:0] {
    CH_HIZ  = 2'b00,
    CH_LOW  = 2'b01,
    CH_HIGH = 2'b10
  } ch_drive_e;
endpackage

// File: rtl/row_scan_chain.sv
module row_scan_chain #(
  parameter int NUM_CH = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed,
  input  logic              dir,
  input  logic              a_in,
  input  logic              b_in,
  output logic [NUM_CH-1:0] stage_q
);
  localparam logic [NUM_CH-1:0] TOKEN_LO = {{(NUM_CH-1){1'b0}}, 1'b1};
  localparam logic [NUM_CH-1:0] TOKEN_HI = {1'b1, {(NUM_CH-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (seed) begin
      stage_q <= dir ? TOKEN_LO : TOKEN_HI;
    end else if (dir) begin
      stage_q <= {stage_q[NUM_CH-2:0], a_in};
    end else begin
      stage_q <= {b_in, stage_q[NUM_CH-1:1]};
    end
  end
endmodule

// File: rtl/row_end_pins.sv
module row_end_pins #(
  parameter int NUM_CH = 40
) (
  input  logic              dir,
  input  logic [NUM_CH-1:0] stage,
  output logic              a_out,
  output logic              a_en,
  output logic              b_out,
  output logic              b_en
);
  // The end that receives data releases its pin so a neighbour can drive it.
  assign b_en  = dir;
  assign a_en  = ~dir;
  assign b_out = dir ? stage[NUM_CH-1] : 1'b0;
  assign a_out = dir ? 1'b0 : stage[0];
endmodule

// File: rtl/row_channel_drv.sv
module row_channel_drv
  import row_scan_pkg::*;
(
  input  logic      active,
  input  logic      pol,
  input  logic      oe,
  output ch_drive_e drv
);
  always_comb begin
    if (oe || !active) drv = CH_HIZ;
    else if (pol)      drv = CH_HIGH;
    else               drv = CH_LOW;
  end
endmodule

// File: rtl/row_scan_driver.sv
module row_scan_driver
  import row_scan_pkg::*;
#(
  parameter int NUM_CH = 40,
  localparam int CODE_W = 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed,
  input  logic              dir,
  input  logic              pol,
  input  logic              oe,
  input  logic              end_a_in,
  output logic              end_a_out,
  output logic              end_a_en,
  input  logic              end_b_in,
  output logic              end_b_out,
  output logic              end_b_en,
  output logic [CODE_W-1:0] ch_state
);
  logic [NUM_CH-1:0] stage_q;

  row_scan_chain #(.NUM_CH(NUM_CH)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .seed    (seed),
    .dir     (dir),
    .a_in    (end_a_in),
    .b_in    (end_b_in),
    .stage_q (stage_q)
  );

  row_end_pins #(.NUM_CH(NUM_CH)) u_pins (
    .dir   (dir),
    .stage (stage_q),
    .a_out (end_a_out),
    .a_en  (end_a_en),
    .b_out (end_b_out),
    .b_en  (end_b_en)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    ch_drive_e drv;
    row_channel_drv u_drv (
      .active (stage_q[ch]),
      .pol    (pol),
      .oe     (oe),
      .drv    (drv)
    );
    assign ch_state[2*ch +: 2] = drv;
  end
endmodule

// File: rtl/row_scan_driver_chk.sv
module row_scan_driver_chk #(
  parameter int NUM_CH = 40
) (
  input logic                clk,
  input logic                rst_n,
  input logic                seed,
  input logic                dir,
  input logic                pol,
  input logic                oe,
  input logic                end_a_in,
  input logic                end_a_out,
  input logic                end_a_en,
  input logic                end_b_in,
  input logic                end_b_out,
  input logic                end_b_en,
  input logic [2*NUM_CH-1:0] ch_state,
  input logic [NUM_CH-1:0]   stage_q
);
  logic any_bad;
  always_comb begin
    any_bad = 1'b0;
    for (int i = 0; i < NUM_CH; i++) any_bad = any_bad | (&ch_state[2*i +: 2]);
  end

  AST_SEED_UP: assert property (@(posedge clk) disable iff (!rst_n)
    seed && dir |=> stage_q == NUM_CH'(1)); // R2
  AST_SEED_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    seed && !dir |=> stage_q == {1'b1, {(NUM_CH-1){1'b0}}}); // R3
  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    !seed && dir |=> stage_q == {$past(stage_q[NUM_CH-2:0]), $past(end_a_in)}); // R4
  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !seed && !dir |=> stage_q == {$past(end_b_in), $past(stage_q[NUM_CH-1:1])}); // R5
  AST_CASCADE_END: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({end_a_en, end_b_en}) &&
    (dir ? (end_b_en && end_b_out == stage_q[NUM_CH-1])
         : (end_a_en && end_a_out == stage_q[0]))); // R6
  AST_DRIVE_POL: assert property (@(posedge clk) disable iff (!rst_n)
    !oe && stage_q[0] |-> ch_state[1:0] == (pol ? 2'b10 : 2'b01)); // R7
  AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_q[NUM_CH-1] |-> ch_state[2*NUM_CH-1 -: 2] == 2'b00); // R8
  AST_OE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> ch_state == '0); // R9
  AST_NO_CODE11: assert property (@(posedge clk) disable iff (!rst_n)
    !any_bad); // R10
  AST_SEED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    seed |=> $countones(stage_q) == 1); // R11
endmodule

bind row_scan_driver row_scan_driver_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .seed      (seed),
  .dir       (dir),
  .pol       (pol),
  .oe        (oe),
  .end_a_in  (end_a_in),
  .end_a_out (end_a_out),
  .end_a_en  (end_a_en),
  .end_b_in  (end_b_in),
  .end_b_out (end_b_out),
  .end_b_en  (end_b_en),
  .ch_state  (ch_state),
  .stage_q   (stage_q)
);

// File: tb/row_scan_driver_test.sv
module row_scan_driver_test;
  localparam int N = 40;
  localparam logic [5:0] NONE = 6'd63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seed = 1'b0, dir = 1'b1, pol = 1'b1, oe = 1'b0;
  logic end_a_in = 1'b0, end_b_in = 1'b0;
  logic end_a_out, end_a_en, end_b_out, end_b_en;
  logic [2*N-1:0] ch_state;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  row_scan_driver #(.NUM_CH(N)) uut (
    .clk(clk), .rst_n(rst_n), .seed(seed), .dir(dir), .pol(pol), .oe(oe),
    .end_a_in(end_a_in), .end_a_out(end_a_out), .end_a_en(end_a_en),
    .end_b_in(end_b_in), .end_b_out(end_b_out), .end_b_en(end_b_en),
    .ch_state(ch_state)
  );

  // Vector fields: seed, dir, pol, oe, expected token index (63 = no token)
  localparam logic [9:0] VEC [0:11] = '{
    10'b1110_000000,  // R2 seed upward
    10'b0110_000001,  // R4
    10'b0100_000010,  // R7 low polarity
    10'b0111_000011,  // R9 disabled
    10'b0010_000010,  // R5 reverse
    10'b0000_000001,  // R5
    10'b1010_100111,  // R3 seed downward
    10'b0010_100110,  // R5
    10'b0110_100111,  // R6 token at B end
    10'b0110_111111,  // R4 token leaves
    10'b0010_111111,  // R8 empty chain
    10'b1100_000000   // R2 seed again
  };

  function automatic logic [2*N-1:0] exp_codes(logic [N-1:0] m, logic p, logic o);
    logic [2*N-1:0] r = '0;
    for (int i = 0; i < N; i++)
      if (!o && m[i]) r[2*i +: 2] = p ? 2'b10 : 2'b01;
    return r;
  endfunction

  task automatic check(string tag, logic [2*N-1:0] act, logic [2*N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag, logic [N-1:0] m);
    logic bad = 1'b0;
    check({tag, " codes"}, ch_state, exp_codes(m, pol, oe));
    check({tag, " R6 pins"}, 80'({end_a_en, end_a_out, end_b_en, end_b_out}),
          dir ? 80'({2'b00, 1'b1, m[N-1]}) : 80'({1'b1, m[0], 2'b00}));
    for (int i = 0; i < N; i++) bad = bad | (&ch_state[2*i +: 2]);
    check({tag, " R10 no 11"}, 80'(bad), 80'(0));
  endtask

  task automatic step(logic s, logic d, logic p, logic o, logic ai, logic bi);
    @(negedge clk);
    seed = s; dir = d; pol = p; oe = o; end_a_in = ai; end_b_in = bi;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #2;
    check("R1 reset codes", ch_state, '0);
    check("R1 R6 reset pins dir1", 80'({end_a_en, end_b_en}), 80'(2'b01));
    dir = 1'b0;
    #1;
    check("R6 reset pins dir0", 80'({end_a_en, end_b_en}), 80'(2'b10));
    @(negedge clk);
    rst_n = 1'b1;
    dir = 1'b1;

    for (int k = 0; k < 12; k++) begin
      logic [9:0] v = VEC[k];
      logic [N-1:0] m = (v[5:0] == NONE) ? '0 : (N'(1) << v[5:0]);
      step(v[9], v[8], v[7], v[6], 1'b0, 1'b0);
      check_all($sformatf("vector %0d", k), m);
    end

    // R4: serial input at A enters stage 0 (token already in stage 0)
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    check_all("R4 inject A", N'(3));
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check_all("R4 shift pair", N'(6));
    // R11: seed wins over two tokens and A input
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    check_all("R11 seed overrides", N'(1));
    // R5: serial input at B enters stage 39 while stage 0 leaves
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    check_all("R5 inject B", N'(1) << (N - 1));
    // R11: seed downward with B input high leaves a single token
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    check_all("R11 R3 seed down", N'(1) << (N - 1));
    // R9: oe high hides token under either polarity
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R9 oe pol0", ch_state, '0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check_all("R8 R7 after oe", N'(1) << (N - 3));
    // R1: asynchronous reset mid-cycle
    #1 rst_n = 1'b0;
    #1;
    check("R1 async clear", ch_state, '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule